// File: doc/BRIEF.md
# USB OUT Endpoint Handshake Controller

This block picks the handshake returned to the host for each bulk or interrupt OUT transaction addressed to one of the device's receive endpoints. The USB packet engine presents a token with an endpoint number, then any received data strobes, then an end-of-transaction pulse. The controller answers with STALL, ACK or NAK. It gates the receive FIFO write strobe, and it pulses a FIFO flush after a stalled transaction. It also keeps per-endpoint status flags and per-endpoint interrupt bits.

The processor reaches the block through a small four-word register port. It selects an endpoint and reads that endpoint's latched status. It arms the FIFO enable bit and sets or clears the halt bit. It acknowledges interrupts by writing ones. Status flags stay latched until the processor drops the select bit, so each transaction outcome is seen before the next one can be recorded. A global input chooses whether NAKed transactions are reported.

Top module: `usb_out_hs_ctrl`

## Requirements
- R1: After reset, hs_o is 0 (no handshake), fifo_wr_o, fifo_flush_o and irq_o are 0, and every endpoint's flags, FIFO enable, halt and interrupt bits are 0.
- R2: A token to endpoint e (1..NUM_EP) makes hs_o show the handshake from the cycle after the token until the cycle after txn_end_i. The handshake is STALL (3) if e is halted, whatever its FIFO enable. Otherwise it is ACK (1) if FIFO enable is set, and NAK (2) if not.
- R3: fifo_wr_o follows rx_valid_i only during an ACKed transaction. It stays 0 during NAK and STALL transactions.
- R4: The end of an ACKed transaction sets the endpoint's ACK flag and interrupt bit and clears its FIFO enable. The next transaction is therefore NAKed until the processor re-arms the endpoint.
- R5: The end of a STALLed transaction sets the STALL flag and interrupt bit and clears FIFO enable. fifo_flush_o pulses high for exactly the one cycle after the end cycle.
- R6: With nak_en_i low, the end of a NAKed transaction leaves the NAK flag and the interrupt bit clear. With nak_en_i high, it sets both.
- R7: Address 3 reads the interrupt pending bits, where bit e belongs to endpoint e. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. irq_o is the OR of all pending bits.
- R8: Address 0 holds {select bit at bit 4, endpoint number at bits 3:0}. Address 1 reads the selected endpoint's status: bit0 ACK, bit1 NAK, bit2 STALL, bit3 FIFO enable, bit4 halt. It reads 0 while the select bit is clear.
- R9: A write to address 0 that clears a set select bit clears the ACK, NAK and STALL flags of the endpoint that was selected. FIFO enable and halt are kept.
- R10: A write to address 2 acts on the selected endpoint only while the select bit is set: bit0 sets FIFO enable, bit1 sets halt, and bit2 clears halt (bit1 wins if both are set).
- R11: When a transaction end and a register write hit the same endpoint in the same cycle, the flag or interrupt bit set by the transaction wins over the clear.
- R12: A token to endpoint 0 or above NUM_EP is ignored: hs_o stays 0, and its txn_end_i changes no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nak_en_i | input | 1 | Report NAKed transactions |
| tok_i | input | 1 | OUT token strobe |
| tok_ep_i | input | EP_W | Endpoint number of the token |
| rx_valid_i | input | 1 | Received data word strobe |
| txn_end_i | input | 1 | Transaction end strobe |
| hs_o | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| fifo_wr_o | output | 1 | Receive FIFO write enable |
| fifo_flush_o | output | 1 | Receive FIFO flush pulse |
| irq_o | output | 1 | Any endpoint interrupt pending |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |

## Verification
The bench arms an endpoint that is also halted and expects STALL with no FIFO writes. A design that let FIFO enable win would ACK and store the data. It then expects the halt bit to survive a deselect while the STALL flag is cleared. A design that cleared everything would lose the halt, and one that cleared nothing would report stale flags. Two transactions end in the same cycle as an interrupt-clear write and as a deselect write. A design that let the software clear win would drop the event. The bench also checks that one ACK disarms the endpoint, that NAKs stay silent with reporting off, and that tokens to endpoint 0 draw no handshake.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam logic [1:0] A_SEL  = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_IRQ  = 2'd3;

  localparam int ST_ACK   = 0;
  localparam int ST_NAK   = 1;
  localparam int ST_STALL = 2;
  localparam int ST_FEN   = 3;
  localparam int ST_HALT  = 4;
  localparam int ST_W     = 5;
endpackage

// File: rtl/usb_hs_decide.sv
module usb_hs_decide
  import usb_hs_pkg::*;
(
  input  logic ok_i,
  input  logic halt_i,
  input  logic fen_i,
  output hs_e  hs_o
);
  always_comb begin
    if (!ok_i)       hs_o = HS_NONE;
    else if (halt_i) hs_o = HS_STALL;  // halt outranks fifo enable
    else if (fen_i)  hs_o = HS_ACK;
    else             hs_o = HS_NAK;
  end
endmodule

// File: rtl/usb_ep_flags.sv
module usb_ep_flags
  import usb_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nak_en_i,
  input  logic evt_i,
  input  hs_e  evt_hs_i,
  input  logic clr_stat_i,
  input  logic set_fen_i,
  input  logic set_halt_i,
  input  logic clr_halt_i,
  input  logic clr_irq_i,
  output logic ack_o,
  output logic nak_o,
  output logic stall_o,
  output logic fen_o,
  output logic halt_o,
  output logic irq_o
);
  logic is_ack, is_nak, is_stall, rep_nak;

  assign is_ack   = evt_i && (evt_hs_i == HS_ACK);
  assign is_nak   = evt_i && (evt_hs_i == HS_NAK);
  assign is_stall = evt_i && (evt_hs_i == HS_STALL);
  assign rep_nak  = is_nak && nak_en_i;

  // hardware sets win over software clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      nak_o   <= 1'b0;
      stall_o <= 1'b0;
      fen_o   <= 1'b0;
      halt_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      ack_o   <= (ack_o && !clr_stat_i) || is_ack;
      nak_o   <= (nak_o && !clr_stat_i) || rep_nak;
      stall_o <= (stall_o && !clr_stat_i) || is_stall;
      irq_o   <= (irq_o && !clr_irq_i) || is_ack || is_stall || rep_nak;
      if (is_ack || is_stall) fen_o <= 1'b0;
      else if (set_fen_i)     fen_o <= 1'b1;
      halt_o  <= set_halt_i || (halt_o && !clr_halt_i);
    end
  end
endmodule

// File: rtl/usb_hs_regs.sv
module usb_hs_regs
  import usb_hs_pkg::*;
#(
  parameter int EP_W = 4,
  parameter int DW   = 16,
  localparam int EP_SPAN = 1 << EP_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [EP_SPAN-1:0] ack_v_i,
  input  logic [EP_SPAN-1:0] nak_v_i,
  input  logic [EP_SPAN-1:0] stall_v_i,
  input  logic [EP_SPAN-1:0] fen_v_i,
  input  logic [EP_SPAN-1:0] halt_v_i,
  input  logic [EP_SPAN-1:0] irq_v_i,
  output logic [DW-1:0]      rdata_o,
  output logic [EP_SPAN-1:0] clr_stat_v_o,
  output logic [EP_SPAN-1:0] set_fen_v_o,
  output logic [EP_SPAN-1:0] set_halt_v_o,
  output logic [EP_SPAN-1:0] clr_halt_v_o,
  output logic [EP_SPAN-1:0] clr_irq_v_o
);
  logic            sel_q;
  logic [EP_W-1:0] sel_ep_q;
  logic [EP_SPAN-1:0] ep_oh, sel_oh;
  logic wr_sel, wr_ctrl, wr_irq, deselect;
  logic [ST_W-1:0] stat;

  assign ep_oh    = EP_SPAN'(1) << sel_ep_q;
  assign sel_oh   = sel_q ? ep_oh : '0;
  assign wr_sel   = we_i && (addr_i == A_SEL);
  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_irq   = we_i && (addr_i == A_IRQ);
  assign deselect = wr_sel && sel_q && !wdata_i[EP_W];

  assign clr_stat_v_o = deselect ? ep_oh : '0;
  assign set_fen_v_o  = (wr_ctrl && wdata_i[0]) ? sel_oh : '0;
  assign set_halt_v_o = (wr_ctrl && wdata_i[1]) ? sel_oh : '0;
  assign clr_halt_v_o = (wr_ctrl && wdata_i[2]) ? sel_oh : '0;
  assign clr_irq_v_o  = wr_irq ? wdata_i[EP_SPAN-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b0;
      sel_ep_q <= '0;
    end else if (wr_sel) begin
      sel_q    <= wdata_i[EP_W];
      sel_ep_q <= wdata_i[EP_W-1:0];
    end
  end

  always_comb begin
    stat            = '0;
    stat[ST_ACK]    = ack_v_i[sel_ep_q];
    stat[ST_NAK]    = nak_v_i[sel_ep_q];
    stat[ST_STALL]  = stall_v_i[sel_ep_q];
    stat[ST_FEN]    = fen_v_i[sel_ep_q];
    stat[ST_HALT]   = halt_v_i[sel_ep_q];
    rdata_o = '0;
    unique case (addr_i)
      A_SEL:   rdata_o[EP_W:0]      = {sel_q, sel_ep_q};
      A_STAT:  rdata_o[ST_W-1:0]    = sel_q ? stat : '0;
      A_IRQ:   rdata_o[EP_SPAN-1:0] = irq_v_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_out_hs_ctrl.sv
module usb_out_hs_ctrl
  import usb_hs_pkg::*;
#(
  parameter int NUM_EP = 15,
  parameter int EP_W   = 4,
  parameter int DW     = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            nak_en_i,
  input  logic            tok_i,
  input  logic [EP_W-1:0] tok_ep_i,
  input  logic            rx_valid_i,
  input  logic            txn_end_i,
  output logic [1:0]      hs_o,
  output logic            fifo_wr_o,
  output logic            fifo_flush_o,
  output logic            irq_o,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o
);
  localparam int EP_SPAN = 1 << EP_W;

  logic [EP_SPAN-1:0] ep_ok_v, evt_v;
  logic [EP_SPAN-1:0] ack_v, nak_v, stall_v, fen_v, halt_v, irq_v;
  logic [EP_SPAN-1:0] clr_stat_v, set_fen_v, set_halt_v, clr_halt_v, clr_irq_v;

  logic            act_q, flush_q, evt;
  logic [EP_W-1:0] cur_ep_q;
  hs_e             hs_q, dec_hs;

  usb_hs_decide u_dec (
    .ok_i   (tok_i && ep_ok_v[tok_ep_i]),
    .halt_i (halt_v[tok_ep_i]),
    .fen_i  (fen_v[tok_ep_i]),
    .hs_o   (dec_hs)
  );

  assign evt = txn_end_i && act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      hs_q     <= HS_NONE;
      cur_ep_q <= '0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= evt && (hs_q == HS_STALL);
      if (tok_i) begin
        act_q    <= (dec_hs != HS_NONE);
        hs_q     <= dec_hs;
        cur_ep_q <= tok_ep_i;
      end else if (evt) begin
        act_q <= 1'b0;
        hs_q  <= HS_NONE;
      end
    end
  end

  assign hs_o         = hs_q;
  assign fifo_wr_o    = act_q && rx_valid_i && (hs_q == HS_ACK);
  assign fifo_flush_o = flush_q;
  assign irq_o        = |irq_v;

  for (genvar i = 0; i < EP_SPAN; i++) begin : g_ep
    if (i >= 1 && i <= NUM_EP) begin : g_on
      assign ep_ok_v[i] = 1'b1;
      assign evt_v[i]   = evt && (cur_ep_q == EP_W'(i));
      usb_ep_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .nak_en_i   (nak_en_i),
        .evt_i      (evt_v[i]),
        .evt_hs_i   (hs_q),
        .clr_stat_i (clr_stat_v[i]),
        .set_fen_i  (set_fen_v[i]),
        .set_halt_i (set_halt_v[i]),
        .clr_halt_i (clr_halt_v[i]),
        .clr_irq_i  (clr_irq_v[i]),
        .ack_o      (ack_v[i]),
        .nak_o      (nak_v[i]),
        .stall_o    (stall_v[i]),
        .fen_o      (fen_v[i]),
        .halt_o     (halt_v[i]),
        .irq_o      (irq_v[i])
      );
    end else begin : g_off
      assign ep_ok_v[i] = 1'b0;
      assign evt_v[i]   = 1'b0;
      assign ack_v[i]   = 1'b0;
      assign nak_v[i]   = 1'b0;
      assign stall_v[i] = 1'b0;
      assign fen_v[i]   = 1'b0;
      assign halt_v[i]  = 1'b0;
      assign irq_v[i]   = 1'b0;
    end
  end

  usb_hs_regs #(.EP_W(EP_W), .DW(DW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .ack_v_i      (ack_v),
    .nak_v_i      (nak_v),
    .stall_v_i    (stall_v),
    .fen_v_i      (fen_v),
    .halt_v_i     (halt_v),
    .irq_v_i      (irq_v),
    .rdata_o      (reg_rdata_o),
    .clr_stat_v_o (clr_stat_v),
    .set_fen_v_o  (set_fen_v),
    .set_halt_v_o (set_halt_v),
    .clr_halt_v_o (clr_halt_v),
    .clr_irq_v_o  (clr_irq_v)
  );
endmodule

// File: rtl/usb_out_hs_chk.sv
module usb_out_hs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       nak_en_i,
  input logic       tok_i,
  input logic       txn_end_i,
  input logic [1:0] hs_o,
  input logic       fifo_wr_o,
  input logic       fifo_flush_o,
  input logic       irq_o,
  input logic       reg_we_i,
  input logic [1:0] reg_addr_i
);
  a_r3_wr_only_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> (hs_o == 2'd1));

  a_r5_flush_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_o |-> ($past(txn_end_i) && ($past(hs_o) == 2'd3)));

  a_r5_flush_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_flush_o |=> !fifo_flush_o);

  a_r7_irq_fall_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i && (reg_addr_i == 2'd3)));

  a_r6_nak_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_end_i && (hs_o == 2'd2) && !nak_en_i && !irq_o) |=> !irq_o);

  a_r2_hs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hs_o != 2'd0) && !txn_end_i && !tok_i) |=> $stable(hs_o));
endmodule

bind usb_out_hs_ctrl usb_out_hs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nak_en_i     (nak_en_i),
  .tok_i        (tok_i),
  .txn_end_i    (txn_end_i),
  .hs_o         (hs_o),
  .fifo_wr_o    (fifo_wr_o),
  .fifo_flush_o (fifo_flush_o),
  .irq_o        (irq_o),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i)
);

// File: tb/sim_usb_out_hs_ctrl.sv
`timescale 1ns/1ps
module sim_usb_out_hs_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nak_en = 1'b0, tok = 1'b0, rx_valid = 1'b0, txn_end = 1'b0;
  logic [3:0]  tok_ep = '0;
  logic [1:0]  hs;
  logic        fifo_wr, fifo_flush, irq;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  usb_out_hs_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .nak_en_i(nak_en), .tok_i(tok), .tok_ep_i(tok_ep),
    .rx_valid_i(rx_valid), .txn_end_i(txn_end), .hs_o(hs), .fifo_wr_o(fifo_wr),
    .fifo_flush_o(fifo_flush), .irq_o(irq), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_txn(input logic [3:0] ep, input int nb, input bit dw,
                         input logic [1:0] wa, input logic [15:0] wd,
                         output logic [1:0] hs_s, output int wrc,
                         output bit fl, output bit fl2);
    @(negedge clk);
    tok = 1'b1; tok_ep = ep;
    @(negedge clk);
    tok = 1'b0;
    #1 hs_s = hs;
    wrc = 0;
    for (int i = 0; i < nb; i++) begin
      rx_valid = 1'b1;
      #1 if (fifo_wr) wrc++;
      @(negedge clk);
    end
    rx_valid = 1'b0;
    txn_end = 1'b1;
    if (dw) begin reg_we = 1'b1; reg_addr = wa; reg_wdata = wd; end
    @(negedge clk);
    txn_end = 1'b0; reg_we = 1'b0;
    #1 fl = fifo_flush;
    @(negedge clk);
    #1 fl2 = fifo_flush;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_eq("R1 hs", hs, 0);
    chk_eq("R1 irq_o", irq, 0);
    chk_eq("R1 flush/wr", {fifo_flush, fifo_wr}, 0);
    reg_rd(2'd3, d); chk_eq("R1 irq reg", d, 0);
    reg_wr(2'd0, 16'h0011);
    reg_rd(2'd1, d); chk_eq("R1 ep1 status", d, 0);
    reg_wr(2'd0, 16'h0001);
  endtask

  task automatic t_nak_quiet();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    nak_en = 1'b0;
    run_txn(4'd2, 3, 0, 0, 0, h, w, f, f2);
    chk_eq("R2 nak hs", h, 2);
    chk_eq("R3 no write on nak", w, 0);
    chk_eq("R6 quiet irq_o", irq, 0);
    reg_wr(2'd0, 16'h0012);
    reg_rd(2'd1, d); chk_eq("R6 quiet nak flag", d, 0);
    reg_wr(2'd0, 16'h0002);
  endtask

  task automatic t_nak_report();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    nak_en = 1'b1;
    run_txn(4'd3, 1, 0, 0, 0, h, w, f, f2);
    chk_eq("R2 nak hs", h, 2);
    reg_rd(2'd3, d); chk_eq("R6 irq pending", d, 16'h0008);
    chk_eq("R7 irq_o high", irq, 1);
    reg_wr(2'd0, 16'h0013);
    reg_rd(2'd1, d); chk_eq("R6 nak flag", d, 16'h0002);
    reg_wr(2'd0, 16'h0003);
    reg_wr(2'd3, 16'h0008);
    reg_rd(2'd3, d); chk_eq("R7 w1c", d, 0);
    chk_eq("R7 irq_o low", irq, 0);
    nak_en = 1'b0;
  endtask

  task automatic t_ack();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    reg_wr(2'd0, 16'h0015);
    reg_rd(2'd0, d); chk_eq("R8 select readback", d, 16'h0015);
    reg_wr(2'd2, 16'h0001);
    reg_rd(2'd1, d); chk_eq("R10 fen set", d, 16'h0008);
    run_txn(4'd5, 4, 0, 0, 0, h, w, f, f2);
    chk_eq("R2 ack hs", h, 1);
    chk_eq("R3 fifo writes", w, 4);
    chk_eq("R5 no flush on ack", f, 0);
    reg_rd(2'd1, d); chk_eq("R4 ack flag, fen cleared", d, 16'h0001);
    reg_rd(2'd3, d); chk_eq("R4 ack irq", d, 16'h0020);
    reg_wr(2'd3, 16'h0000);
    reg_rd(2'd3, d); chk_eq("R7 write 0 keeps", d, 16'h0020);
    reg_wr(2'd3, 16'h0020);
    reg_wr(2'd0, 16'h0005);
    reg_rd(2'd1, d); chk_eq("R8 unselected status", d, 0);
    reg_wr(2'd0, 16'h0015);
    reg_rd(2'd1, d); chk_eq("R9 ack flag cleared", d, 0);
    run_txn(4'd5, 2, 0, 0, 0, h, w, f, f2);
    chk_eq("R4 rearm needed", h, 2);
    chk_eq("R3 no write after ack", w, 0);
    reg_wr(2'd0, 16'h0005);
  endtask

  task automatic t_stall();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    reg_wr(2'd0, 16'h0017);
    reg_wr(2'd2, 16'h0003);
    reg_rd(2'd1, d); chk_eq("R10 fen+halt", d, 16'h0018);
    run_txn(4'd7, 2, 0, 0, 0, h, w, f, f2);
    chk_eq("R2 halt beats fen", h, 3);
    chk_eq("R3 no write on stall", w, 0);
    chk_eq("R5 flush pulse", f, 1);
    chk_eq("R5 flush one cycle", f2, 0);
    reg_rd(2'd1, d); chk_eq("R5 stall flag, fen cleared", d, 16'h0014);
    reg_rd(2'd3, d); chk_eq("R5 stall irq", d, 16'h0080);
    reg_wr(2'd0, 16'h0007);
    reg_wr(2'd0, 16'h0017);
    reg_rd(2'd1, d); chk_eq("R9 halt kept", d, 16'h0010);
    reg_wr(2'd2, 16'h0004);
    reg_rd(2'd1, d); chk_eq("R10 halt cleared", d, 0);
    reg_wr(2'd3, 16'h0080);
    reg_wr(2'd0, 16'h0007);
  endtask

  task automatic t_ctrl_unsel();
    logic [15:0] d; logic [1:0] h; int w; bit f, f2;
    reg_wr(2'd0, 16'h0006);
    reg_wr(2'd2, 16'h0003);
    reg_wr(2'd0, 16'h0016);
    reg_rd(2'd1, d); chk_eq("R10 ctrl ignored unselected", d, 0);
    run_txn(4'd6, 1, 0, 0, 0, h, w, f, f2);
    chk_eq("R10 ep6 still naks", h, 2);
    reg_wr(2'd0, 16'h0006);
  endtask

  task automatic t_priority();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    nak_en = 1'b1;
    run_txn(4'd9, 1, 1, 2'd3, 16'h0200, h, w, f, f2);
    reg_rd(2'd3, d); chk_eq("R11 set beats irq clear", d, 16'h0200);
    reg_wr(2'd3, 16'h0200);
    reg_wr(2'd0, 16'h0019);
    run_txn(4'd9, 1, 1, 2'd0, 16'h0009, h, w, f, f2);
    reg_wr(2'd0, 16'h0019);
    reg_rd(2'd1, d); chk_eq("R11 set beats deselect", d, 16'h0002);
    reg_wr(2'd0, 16'h0009);
    reg_wr(2'd3, 16'h0200);
    nak_en = 1'b0;
  endtask

  task automatic t_ep0();
    logic [1:0] h; int w; bit f, f2; logic [15:0] d;
    nak_en = 1'b1;
    run_txn(4'd0, 1, 0, 0, 0, h, w, f, f2);
    chk_eq("R12 ep0 no handshake", h, 0);
    reg_rd(2'd3, d); chk_eq("R12 ep0 no irq", d, 0);
    nak_en = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nak_quiet();
    t_nak_report();
    t_ack();
    t_stall();
    t_ctrl_unsel();
    t_priority();
    t_ep0();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule